// File: doc/BRIEF.md
# SPI Master with Programmable Chip-Select Guard Timing

This block is an SPI master that runs one full-duplex word transfer per start strobe and drives its own active-low chip-select around it. Software never toggles the select line: the controller pulls it low as soon as a transfer is accepted. It then waits a programmable guard interval before the first serial clock edge. After the last serial clock edge it waits a second programmable interval before releasing the select. These two intervals let slow slave devices meet their select-setup and select-hold minimums without an external GPIO select.

Configuration sits in one control register, written through a simple write port while the block is idle. The register holds the serial clock polarity and phase, separate first-bit order for transmit and receive, and two 4-bit guard fields. Each step of a guard field adds one core clock cycle on top of a fixed minimum: 3 cycles of setup and 2 cycles of hold. The serial clock runs at a quarter of the core clock. A transfer is started with a strobe and a parallel transmit word. The received word is presented in parallel, and a one-cycle done pulse marks the end of the transfer.

Top module: `spi_cs_master`

## Requirements
- R1: A start strobe accepted while idle pulls cs_n low and raises busy in the core cycle right after the accepting clock edge.
- R2: The first SCLK edge follows the falling edge of cs_n by exactly 3 + S core cycles, where S is the setup field in control bits [15:12] (0 to 15).
- R3: cs_n rises exactly 2 + H core cycles after the last SCLK edge, where H is the hold field in control bits [19:16] (0 to 15).
- R4: SCLK toggles every 2 core cycles (core clock divided by 4), with exactly 2·W edges per transfer (16 for the default W = 8).
- R5: Outside the shifting phase (idle, setup guard, hold guard) SCLK rests at the polarity level given by control bit [0].
- R6: With phase bit [1] = 0, MOSI is stable across each leading SCLK edge and MISO is captured on leading edges. With bit [1] = 1, both happen on trailing edges. A leading edge is one that moves SCLK away from its rest level.
- R7: Control bit [2] = 1 sends the transmit word LSB first (0 = MSB first). Control bit [3] = 1 places the first received bit in rx_data bit 0 (0 = bit W-1). The two settings are independent.
- R8: done is high for exactly one core cycle, in the same cycle in which cs_n returns high and busy falls, and rx_data holds the complete received word at that point.
- R9: While busy is high, control register writes and further start strobes are ignored. The running transfer and the next one use the configuration written before the start.
- R10: After reset cs_n is high, busy and done are low, and SCLK is low (the control register resets to all zeros).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 32 | Control register write data |
| start | input | 1 | Start a transfer (accepted only when idle) |
| tx_data | input | W | Word to transmit |
| rx_data | output | W | Last received word |
| busy | output | 1 | Transfer in progress, from start until cs_n returns high |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip-select |

## Verification
The select falls in the first core cycle after the accepting edge. The first SCLK edge appears 3 + S cycles after that, later edges follow every 2 cycles, and the select rises 2 + H cycles after the sixteenth edge, together with the done pulse. The bench drives every input on the falling clock edge and samples every output on the falling edge too. It numbers those samples from the start strobe, so each interval is measured as a difference of sample indices and can be compared exactly with the formula. MOSI is taken from the sample just before each sampling-type SCLK transition, and MISO is looped back to MOSI. The received word can then be predicted from the transmit word, the phase and the two bit-order settings.

// File: rtl/spi_csm_pkg.sv
package spi_csm_pkg;

    parameter int DLY_W     = 4;
    parameter int SETUP_MIN = 3;
    parameter int HOLD_MIN  = 2;
    localparam int CNT_W    = $clog2(SETUP_MIN + (1 << DLY_W));

    // control register field positions
    localparam int BIT_CPOL   = 0;
    localparam int BIT_CPHA   = 1;
    localparam int BIT_TX_LSB = 2;
    localparam int BIT_RX_LSB = 3;
    localparam int SETUP_LSB  = 12;
    localparam int HOLD_LSB   = 16;

    typedef struct packed {
        logic [DLY_W-1:0] hold;
        logic [DLY_W-1:0] setup;
        logic             rx_lsb;
        logic             tx_lsb;
        logic             cpha;
        logic             cpol;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } state_t;

    function automatic cfg_t decode_cfg(input logic [31:0] w);
        cfg_t c;
        c.cpol   = w[BIT_CPOL];
        c.cpha   = w[BIT_CPHA];
        c.tx_lsb = w[BIT_TX_LSB];
        c.rx_lsb = w[BIT_RX_LSB];
        c.setup  = w[SETUP_LSB +: DLY_W];
        c.hold   = w[HOLD_LSB +: DLY_W];
        return c;
    endfunction

endpackage

// File: rtl/spi_csm_cfg.sv
module spi_csm_cfg
    import spi_csm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    input  logic        busy,
    output cfg_t        cfg
);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[31:HOLD_LSB+DLY_W], wdata[SETUP_LSB-1:BIT_RX_LSB+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we && !busy) begin
            cfg <= decode_cfg(wdata);
        end
    end

    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg)); // R9

endmodule

// File: rtl/spi_csm_timer.sv
module spi_csm_timer
    import spi_csm_pkg::*;
#(
    parameter int W        = 8,
    parameter int SCLK_DIV = 4,
    parameter int EC_W     = $clog2(2*W+1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             cpol,
    input  logic [DLY_W-1:0] setup_sel,
    input  logic [DLY_W-1:0] hold_sel,
    output state_t           state,
    output logic             sclk,
    output logic             done,
    output logic             edge_fire,
    output logic [EC_W-1:0]  edge_k
);

    localparam int EDGES = 2 * W;
    localparam int HALF  = SCLK_DIV / 2;
    localparam int HC_W  = $clog2(HALF + 1);

    logic [CNT_W-1:0] cnt;
    logic [HC_W-1:0]  hcnt;
    logic [EC_W-1:0]  ecnt;
    logic             half_up;

    assign half_up   = (hcnt == HC_W'(HALF - 1));
    assign edge_fire = ((state == ST_SETUP) && (cnt == '0)) ||
                       ((state == ST_SHIFT) && half_up);
    assign edge_k    = (state == ST_SETUP) ? EC_W'(1) : ecnt + EC_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            hcnt  <= '0;
            ecnt  <= '0;
            sclk  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    sclk <= cpol;
                    ecnt <= '0;
                    if (accept) begin
                        state <= ST_SETUP;
                        cnt   <= CNT_W'(SETUP_MIN - 1) + CNT_W'(setup_sel);
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        state <= ST_SHIFT;
                        sclk  <= ~sclk;
                        ecnt  <= EC_W'(1);
                        hcnt  <= '0;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (half_up) begin
                        hcnt <= '0;
                        sclk <= ~sclk;
                        ecnt <= edge_k;
                        if (edge_k == EC_W'(EDGES)) begin
                            state <= ST_HOLD;
                            cnt   <= CNT_W'(HOLD_MIN - 1) + CNT_W'(hold_sel);
                        end
                    end else begin
                        hcnt <= hcnt + HC_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SCLK_REST_GUARD: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_SETUP) || (state == ST_HOLD)) |-> (sclk == cpol)); // R5
    AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ecnt <= EC_W'(EDGES)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_HOLD_SCLK_STILL: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_HOLD) && $past(state == ST_HOLD)) |-> $stable(sclk)); // R3

endmodule

// File: rtl/spi_csm_shifter.sv
module spi_csm_shifter #(
    parameter int W    = 8,
    parameter int EC_W = $clog2(2*W+1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [W-1:0]    tx_word,
    input  logic            cpha,
    input  logic            tx_lsb,
    input  logic            rx_lsb,
    input  logic            edge_fire,
    input  logic [EC_W-1:0] edge_k,
    input  logic            miso,
    output logic            mosi,
    output logic [W-1:0]    rx_word
);

    localparam int EDGES = 2 * W;
    localparam int PW    = (W > 1) ? $clog2(W) : 1;
    localparam int IW    = PW + 1;

    logic [W-1:0]  tx_reg;
    logic [IW-1:0] tx_idx;
    logic [IW-1:0] rx_idx;
    logic          leading;
    logic          sample_now;
    logic          advance_now;

    function automatic logic [PW-1:0] bit_at(input logic [IW-1:0] idx, input logic lsb);
        return lsb ? PW'(idx) : PW'(W - 1) - PW'(idx);
    endfunction

    assign leading     = edge_k[0];
    assign sample_now  = edge_fire && (cpha ? !leading : leading);
    assign advance_now = edge_fire && (cpha ? (leading && edge_k != EC_W'(1))
                                            : (!leading && edge_k != EC_W'(EDGES)));
    assign mosi        = tx_reg[bit_at(tx_idx, tx_lsb)];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_reg  <= '0;
            tx_idx  <= '0;
            rx_idx  <= '0;
            rx_word <= '0;
        end else if (load) begin
            tx_reg <= tx_word;
            tx_idx <= '0;
            rx_idx <= '0;
        end else begin
            if (advance_now) tx_idx <= tx_idx + IW'(1);
            if (sample_now) begin
                rx_word[bit_at(rx_idx, rx_lsb)] <= miso;
                rx_idx <= rx_idx + IW'(1);
            end
        end
    end

    AST_TX_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        tx_idx < IW'(W)); // R7
    AST_MOSI_STEADY_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (sample_now && !$past(load)) |-> $stable(mosi)); // R6

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
    import spi_csm_pkg::*;
#(
    parameter int W        = 8,
    parameter int SCLK_DIV = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  logic [31:0]  cfg_wdata,
    input  logic         start,
    input  logic [W-1:0] tx_data,
    output logic [W-1:0] rx_data,
    output logic         busy,
    output logic         done,
    output logic         sclk,
    output logic         mosi,
    input  logic         miso,
    output logic         cs_n
);

    localparam int EC_W = $clog2(2 * W + 1);

    cfg_t            cfg;
    state_t          state;
    logic            accept;
    logic            edge_fire;
    logic [EC_W-1:0] edge_k;

    assign busy   = (state != ST_IDLE);
    assign cs_n   = (state == ST_IDLE);
    assign accept = start && (state == ST_IDLE);

    spi_csm_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .busy  (busy),
        .cfg   (cfg)
    );

    spi_csm_timer #(.W(W), .SCLK_DIV(SCLK_DIV), .EC_W(EC_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cpol      (cfg.cpol),
        .setup_sel (cfg.setup),
        .hold_sel  (cfg.hold),
        .state     (state),
        .sclk      (sclk),
        .done      (done),
        .edge_fire (edge_fire),
        .edge_k    (edge_k)
    );

    spi_csm_shifter #(.W(W), .EC_W(EC_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .tx_word   (tx_data),
        .cpha      (cfg.cpha),
        .tx_lsb    (cfg.tx_lsb),
        .rx_lsb    (cfg.rx_lsb),
        .edge_fire (edge_fire),
        .edge_k    (edge_k),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_data)
    );

    AST_START_DROPS_CS: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> !cs_n); // R1
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && $past(!cs_n))); // R8

endmodule

// File: tb/spi_cs_master_tb_top.sv
module spi_cs_master_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [31:0]  cfg_wdata = '0;
    logic         start = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic [W-1:0] rx_data;
    logic         busy, done, sclk, mosi, cs_n;
    logic         miso;

    assign miso = mosi;

    spi_cs_master #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .start(start), .tx_data(tx_data), .rx_data(rx_data), .busy(busy),
        .done(done), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;

    // bench model of the control register
    logic       e_cpol = 0, e_cpha = 0, e_txl = 0, e_rxl = 0;
    int         e_s = 0, e_h = 0;

    // measurement results
    int         m_cs, m_first, m_last, m_rel, m_edges, m_dones, m_nb;
    logic [W-1:0] m_cap;
    logic       m_rest_start, m_rest_end, m_busy_i1, m_end_ok, m_post_ok;
    logic       inj_en = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic pol, input logic pha, input logic tl,
                                        input logic rl, input int s, input int h);
        return {12'd0, 4'(h), 4'(s), 8'd0, rl, tl, pha, pol};
    endfunction

    task automatic write_cfg(input logic pol, input logic pha, input logic tl,
                             input logic rl, input int s, input int h);
        @(negedge clk);
        cfg_we = 1; cfg_wdata = enc(pol, pha, tl, rl, s, h);
        @(negedge clk);
        cfg_we = 0;
        e_cpol = pol; e_cpha = pha; e_txl = tl; e_rxl = rl; e_s = s; e_h = h;
    endtask

    // run one transfer, measuring everything in negedge sample indices
    task automatic do_xfer(input logic [W-1:0] tx);
        logic prev_sclk, prev_mosi, lead;
        int i;
        m_cs = -1; m_first = -1; m_last = -1; m_rel = -1;
        m_edges = 0; m_dones = 0; m_nb = 0; m_cap = '0;
        @(negedge clk);
        m_rest_start = (sclk == e_cpol);
        prev_sclk = sclk; prev_mosi = mosi;
        start = 1; tx_data = tx;
        @(negedge clk);
        start = 0;
        m_busy_i1 = busy;
        i = 1;
        forever begin
            if (!cs_n && m_cs < 0) m_cs = i;
            if (done) m_dones++;
            if (sclk != prev_sclk) begin
                m_edges++;
                if (m_first < 0) m_first = i;
                m_last = i;
                lead = (sclk != e_cpol);
                if ((lead ^ e_cpha) && m_nb < W) begin
                    m_cap[m_nb] = prev_mosi;
                    m_nb++;
                end
            end
            if (cs_n && m_cs >= 0) begin
                m_rel = i;
                m_end_ok = done && !busy;
                m_rest_end = (sclk == e_cpol);
                break;
            end
            if (inj_en && i == 6) begin
                cfg_we = 1; cfg_wdata = enc(~e_cpol, e_cpha, e_txl, e_rxl, 15, 15);
                start = 1; tx_data = ~tx;
            end
            if (inj_en && i == 7) begin
                cfg_we = 0; start = 0; tx_data = tx;
            end
            if (i > 400) begin
                chk(0, "R8 transfer never ended", i, 400);
                break;
            end
            prev_sclk = sclk; prev_mosi = mosi;
            @(negedge clk);
            i++;
        end
        @(negedge clk);
        m_post_ok = !done && cs_n && !busy;
    endtask

    // common checks of one finished transfer against the bench model
    task automatic check_xfer(input logic [W-1:0] tx, input string tag);
        logic [W-1:0] exp_line, exp_rx;
        for (int j = 0; j < W; j++) begin
            exp_line[j] = tx[e_txl ? j : W - 1 - j];
            exp_rx[e_rxl ? j : W - 1 - j] = exp_line[j];
        end
        chk(m_cs == 1 && m_busy_i1, {"R1 cs_n low after start ", tag}, m_cs, 1);
        chk(m_first - m_cs == 3 + e_s, {"R2 setup gap ", tag}, m_first - m_cs, 3 + e_s);
        chk(m_rel - m_last == 2 + e_h, {"R3 hold gap ", tag}, m_rel - m_last, 2 + e_h);
        chk(m_edges == 2 * W, {"R4 sclk edge count ", tag}, m_edges, 2 * W);
        chk(m_last - m_first == 2 * (2 * W - 1), {"R4 sclk period ", tag},
            m_last - m_first, 2 * (2 * W - 1));
        chk(m_rest_start && m_rest_end, {"R5 sclk rest level ", tag}, int'(sclk), int'(e_cpol));
        chk(m_cap == exp_line, {"R6 mosi bit stream ", tag}, int'(m_cap), int'(exp_line));
        chk(rx_data == exp_rx, {"R7 received word ", tag}, int'(rx_data), int'(exp_rx));
        chk(m_end_ok && m_dones == 1 && m_post_ok, {"R8 done pulse ", tag}, m_dones, 1);
    endtask

    task automatic t_reset();
        chk(cs_n == 1 && busy == 0 && done == 0 && sclk == 0, "R10 reset state",
            int'({cs_n, busy, done, sclk}), 8);
    endtask

    task automatic t_timing(input int s, input int h, input logic [W-1:0] tx);
        write_cfg(0, 0, 0, 0, s, h);
        do_xfer(tx);
        check_xfer(tx, $sformatf("timing s=%0d h=%0d", s, h));
    endtask

    task automatic t_mode(input logic pol, input logic pha, input logic [W-1:0] tx);
        write_cfg(pol, pha, 0, 0, 2, 1);
        do_xfer(tx);
        check_xfer(tx, $sformatf("mode cpol=%0d cpha=%0d", pol, pha));
    endtask

    task automatic t_order(input logic tl, input logic rl, input logic pha, input logic [W-1:0] tx);
        write_cfg(pha, pha, tl, rl, 0, 0);
        do_xfer(tx);
        check_xfer(tx, $sformatf("order tx_lsb=%0d rx_lsb=%0d", tl, rl));
    endtask

    task automatic t_busy_ignore();
        write_cfg(0, 1, 0, 0, 1, 1);
        inj_en = 1;
        do_xfer(8'h5C);
        inj_en = 0;
        check_xfer(8'h5C, "R9 during write+start");
        chk(m_first - m_cs == 4, "R9 setup kept", m_first - m_cs, 4);
        do_xfer(8'hA7);
        check_xfer(8'hA7, "R9 next transfer");
        chk(m_rel - m_last == 3 && m_rest_start, "R9 old config persists",
            m_rel - m_last, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_timing(0, 15, 8'hA5);
        t_timing(1, 1, 8'h3C);
        t_timing(7, 0, 8'hF0);
        t_timing(15, 7, 8'h96);
        t_mode(0, 0, 8'hC3);
        t_mode(0, 1, 8'h1E);
        t_mode(1, 0, 8'h81);
        t_mode(1, 1, 8'h6B);
        t_order(1, 0, 0, 8'hB1);
        t_order(0, 1, 1, 8'hB1);
        t_order(1, 1, 0, 8'h4D);
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule